// File: doc/BRIEF.md
# Saturating Trapezoid Shaper

This block turns the running phase word of a digital synthesizer into a trapezoid sample. The phase is folded into a signed triangle, multiplied by a programmable gain and clamped with saturating arithmetic to the symmetric output range. High gain gives a short, steep linear ramp through each zero crossing. Every low phase bit still moves the output along that ramp, so it climbs in fine steps rather than jumping. Scaling the gain inversely with the output frequency keeps the ramp length, counted in samples, the same at any rate.

A mode input chooses between two forms. One passes the clamped value straight to the output. The other sends it through a computed shaping table with a cubic sine-like curve, which rounds the corners of the trapezoid. The block also compares the product of the frequency word, the gain and a settling length against the output limit. It flags the setting when the ramp would be shorter than twice that settling length. The sample and the flag are registered together on each strobed input.

Top module: `trap_shaper`

## Requirements
- R1: While rst_ni is low, sample_o, valid_o and cfg_err_o are all zero.
- R2: valid_o equals valid_i delayed by one clock. The sample and flag presented with valid_i appear on the outputs in the cycle after that edge.
- R3: The phase is folded as follows. Bit 15 is the sign, bit 14 selects the falling quarter, and bits 13:0 are the magnitude. When bit 14 is 1 the magnitude is inverted (m = ~low). The triangle is -m when bit 15 is 1 and m otherwise.
- R4: When triangle*gain exceeds +2047 the output is exactly +2047. Below -2047 it is exactly -2047. It never wraps, including at full-scale triangle with gain 255.
- R5: In linear mode (mode_i=0), the output equals triangle*gain whenever that product lies within -2047..+2047.
- R6: On the ramp, phase codes one LSB apart give outputs that differ by exactly the gain.
- R7: In rounded mode (mode_i=1), let x be the clamped value. If |x| = 2047 the output is x. Otherwise let k = |x|>>5. The output takes the sign of x and the magnitude floor(2047*(3*k*4096 - k^3)/524288).
- R8: cfg_err_o is 1 exactly when freq_i*gain_i*16 > 2047, with a settling length of 16 samples.
- R9: While valid_i is low, sample_o and cfg_err_o hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe; captures a new sample |
| phase_i | input | 16 | Phase accumulator word |
| freq_i | input | 16 | Frequency step word, used for the ramp check |
| gain_i | input | 8 | Unsigned numerical gain |
| mode_i | input | 1 | 0 linear trapezoid, 1 rounded through table |
| sample_o | output | 12 | Signed output sample |
| valid_o | output | 1 | Sample strobe, one cycle after valid_i |
| cfg_err_o | output | 1 | Ramp too short for the settling length |

## Verification
The assertions assume that the inputs are driven to known values once reset is released. They also assume that gain_i is a plain unsigned magnitude, so the sign of the output follows only the phase sign bit. The bench keeps to this by changing inputs only on falling edges and holding every input defined from time zero. Its vectors cover both extremes of the gain and both phase halves. They include products on each side of the 2047 limit and frequency-gain pairs on each side of the settling bound.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic {
    SHAPE_LINEAR = 1'b0,
    SHAPE_ROUND  = 1'b1
  } shape_mode_e;

  // Cubic sine-like curve, zero slope at full scale: lim*(3u-u^3)/2, u=k/n
  function automatic longint cubic_entry(longint k, longint n, longint lim);
    return (lim * (3 * k * n * n - k * k * k)) / (2 * n * n * n);
  endfunction
endpackage

// File: rtl/tri_fold.sv
module tri_fold #(
  parameter int PHASE_W = 16
) (
  input  logic [PHASE_W-1:0]        phase_i,
  output logic signed [PHASE_W-2:0] tri_o
);
  localparam int LOW_W = PHASE_W - 2;

  logic [LOW_W-1:0] mag;

  always_comb begin
    mag   = phase_i[PHASE_W-2] ? ~phase_i[LOW_W-1:0] : phase_i[LOW_W-1:0];
    tri_o = phase_i[PHASE_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/gain_clamp.sv
module gain_clamp #(
  parameter int PHASE_W = 16,
  parameter int GAIN_W  = 8,
  parameter int OUT_W   = 12
) (
  input  logic signed [PHASE_W-2:0] tri_i,
  input  logic [GAIN_W-1:0]         gain_i,
  output logic signed [OUT_W-1:0]   clamp_o
);
  localparam int PROD_W = PHASE_W + GAIN_W;
  localparam int LIM    = 2 ** (OUT_W - 1) - 1;
  localparam logic signed [PROD_W-1:0] POS_LIM = PROD_W'(LIM);
  localparam logic signed [PROD_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(tri_i) * PROD_W'($signed({1'b0, gain_i}));
    if (prod > POS_LIM)      clamp_o = POS_LIM[OUT_W-1:0];
    else if (prod < NEG_LIM) clamp_o = NEG_LIM[OUT_W-1:0];
    else                     clamp_o = prod[OUT_W-1:0];
  end
endmodule

// File: rtl/shape_lut.sv
module shape_lut
  import trap_pkg::*;
#(
  parameter int OUT_W  = 12,
  parameter int TBL_AW = 6
) (
  input  logic signed [OUT_W-1:0] x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int N     = 2 ** TBL_AW;
  localparam int LIM   = 2 ** (OUT_W - 1) - 1;
  localparam int SHIFT = OUT_W - 1 - TBL_AW;

  logic [OUT_W-2:0] tbl [N];

  for (genvar k = 0; k < N; k++) begin : g_tbl
    localparam longint ENTRY = cubic_entry(k, N, LIM);
    assign tbl[k] = ENTRY[OUT_W-2:0];
  end

  logic [OUT_W-1:0]  mag;
  logic [TBL_AW-1:0] idx;
  logic [OUT_W-2:0]  val;

  always_comb begin
    mag = x_i[OUT_W-1] ? OUT_W'(-x_i) : OUT_W'(x_i);
    idx = mag[OUT_W-2:SHIFT];
    val = tbl[idx];
    if (mag == OUT_W'(LIM))  y_o = x_i;
    else if (x_i[OUT_W-1])   y_o = -$signed({1'b0, val});
    else                     y_o = $signed({1'b0, val});
  end
endmodule

// File: rtl/ramp_check.sv
module ramp_check #(
  parameter int FREQ_W     = 16,
  parameter int GAIN_W     = 8,
  parameter int OUT_W      = 12,
  parameter int SETTLE_LEN = 16
) (
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              err_o
);
  localparam int SET_W = $clog2(SETTLE_LEN + 1);
  localparam int REQ_W = FREQ_W + GAIN_W + SET_W;
  localparam int LIM   = 2 ** (OUT_W - 1) - 1;

  logic [REQ_W-1:0] need;

  // ramp spans 2*LIM/(gain*freq) samples; must be >= 2*SETTLE_LEN
  always_comb begin
    need  = REQ_W'(freq_i) * REQ_W'(gain_i) * REQ_W'(SETTLE_LEN);
    err_o = need > REQ_W'(LIM);
  end
endmodule

// File: rtl/trap_shaper.sv
module trap_shaper
  import trap_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int FREQ_W     = 16,
  parameter int GAIN_W     = 8,
  parameter int OUT_W      = 12,
  parameter int TBL_AW     = 6,
  parameter int SETTLE_LEN = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [PHASE_W-1:0]       phase_i,
  input  logic [FREQ_W-1:0]        freq_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic                     mode_i,
  output logic signed [OUT_W-1:0]  sample_o,
  output logic                     valid_o,
  output logic                     cfg_err_o
);
  logic signed [PHASE_W-2:0] tri_w;
  logic signed [OUT_W-1:0]   clamp_w;
  logic signed [OUT_W-1:0]   round_w;
  logic signed [OUT_W-1:0]   next_w;
  logic                      err_w;
  shape_mode_e               mode_sel;

  tri_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase_i (phase_i),
    .tri_o   (tri_w)
  );

  gain_clamp #(.PHASE_W(PHASE_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_clamp (
    .tri_i   (tri_w),
    .gain_i  (gain_i),
    .clamp_o (clamp_w)
  );

  shape_lut #(.OUT_W(OUT_W), .TBL_AW(TBL_AW)) u_lut (
    .x_i (clamp_w),
    .y_o (round_w)
  );

  ramp_check #(.FREQ_W(FREQ_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W),
               .SETTLE_LEN(SETTLE_LEN)) u_ramp (
    .freq_i (freq_i),
    .gain_i (gain_i),
    .err_o  (err_w)
  );

  assign mode_sel = shape_mode_e'(mode_i);
  assign next_w   = (mode_sel == SHAPE_ROUND) ? round_w : clamp_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o  <= '0;
      cfg_err_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sample_o  <= next_w;
        cfg_err_o <= err_w;
      end
    end
  end
endmodule

// File: rtl/trap_shaper_chk.sv
module trap_shaper_chk #(
  parameter int PHASE_W = 16,
  parameter int GAIN_W  = 8,
  parameter int OUT_W   = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [PHASE_W-1:0]      phase_i,
  input logic [GAIN_W-1:0]       gain_i,
  input logic signed [OUT_W-1:0] sample_o,
  input logic                    valid_o,
  input logic                    cfg_err_o
);
  localparam int LIM = 2 ** (OUT_W - 1) - 1;
  localparam logic signed [OUT_W-1:0] POS = OUT_W'(LIM);
  localparam logic signed [OUT_W-1:0] NEG = -POS;

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o <= POS) && (sample_o >= NEG));
  a_r3_neg_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && phase_i[PHASE_W-1]) |=> (sample_o <= 0));
  a_r3_pos_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !phase_i[PHASE_W-1]) |=> (sample_o >= 0));
  a_r8_zero_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_i == '0) |=> !cfg_err_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sample_o) && $stable(cfg_err_o)));
endmodule

bind trap_shaper trap_shaper_chk #(
  .PHASE_W (PHASE_W),
  .GAIN_W  (GAIN_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .phase_i   (phase_i),
  .gain_i    (gain_i),
  .sample_o  (sample_o),
  .valid_o   (valid_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/trap_shaper_bench.sv
module trap_shaper_bench;
  localparam int LIM = 2047;

  typedef struct packed {
    logic [15:0]        phase;
    logic [7:0]         gain;
    logic [15:0]        freq;
    logic signed [11:0] exp_s;
    logic               exp_e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 8'd1,   16'd100, 12'sd0,     1'b0}, // R3 zero phase
    '{16'h0005, 8'd3,   16'd42,  12'sd15,    1'b0}, // R5, R8 126<128
    '{16'h0006, 8'd3,   16'd43,  12'sd18,    1'b1}, // R6 step, R8 129
    '{16'h8005, 8'd3,   16'd0,   -12'sd15,   1'b0}, // R3 sign
    '{16'h4000, 8'd1,   16'd127, 12'sd2047,  1'b0}, // R4 peak, R8 2032
    '{16'hC000, 8'd255, 16'd1,   -12'sd2047, 1'b1}, // R4 full scale
    '{16'h7FFF, 8'd1,   16'd128, 12'sd0,     1'b1}, // R3 fold end, R8 2048
    '{16'h3FFF, 8'd200, 16'd0,   12'sd2047,  1'b0}, // R4
    '{16'h0100, 8'd7,   16'd18,  12'sd1792,  1'b0}, // R5
    '{16'h0124, 8'd7,   16'd19,  12'sd2044,  1'b1}, // R5 edge, R8 133
    '{16'h0125, 8'd7,   16'd0,   12'sd2047,  1'b0}, // R4 just over
    '{16'h8125, 8'd7,   16'd0,   -12'sd2047, 1'b0}, // R4 negative
    '{16'h7F00, 8'd4,   16'd0,   12'sd1020,  1'b0}  // R3 falling quarter
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid = 1'b0;
  logic [15:0]        phase = '0;
  logic [15:0]        freq = '0;
  logic [7:0]         gain = '0;
  logic               mode = 1'b0;
  logic signed [11:0] sample;
  logic               valid_out;
  logic               cfg_err;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  trap_shaper u_trap_shaper (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid),
    .phase_i   (phase),
    .freq_i    (freq),
    .gain_i    (gain),
    .mode_i    (mode),
    .sample_o  (sample),
    .valid_o   (valid_out),
    .cfg_err_o (cfg_err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rounded-mode model taken from R7
  function automatic int round_model(int x);
    longint k, mag, v;
    mag = (x < 0) ? -x : x;
    if (mag == LIM) return x;
    k = mag >> 5;
    v = (2047 * (3 * k * 4096 - k * k * k)) / 524288;
    return (x < 0) ? -int'(v) : int'(v);
  endfunction

  // drive one strobed input; return at the falling edge after capture
  task automatic apply(logic [15:0] p, logic [7:0] g, logic [15:0] f, logic m);
    @(negedge clk);
    phase = p; gain = g; freq = f; mode = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 sample", int'(sample), 0);
    check("R1 valid", int'(valid_out), 0);
    check("R1 err", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].phase, VECS[i].gain, VECS[i].freq, 1'b0);
      check("R2 valid", int'(valid_out), 1);
      check("R5 sample", int'(sample), int'(VECS[i].exp_s));
      check("R8 err", int'(cfg_err), int'(VECS[i].exp_e));
    end

    // R2 strobe lasts one cycle
    @(negedge clk);
    check("R2 valid drop", int'(valid_out), 0);

    // R6 consecutive phase codes step by the gain
    for (int p = 16'h0040; p < 16'h0044; p++) begin
      apply(16'(p), 8'd9, 16'd0, 1'b0);
      check("R6 step", int'(sample), p * 9);
    end

    // R9 hold while strobe low
    apply(16'h0100, 8'd7, 16'd1, 1'b0);
    phase = 16'h4000; gain = 8'd255; freq = 16'hFFFF; mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 hold sample", int'(sample), 1792);
    check("R9 hold err", int'(cfg_err), 0);

    // R7 rounded mode
    apply(16'h0005, 8'd3, 16'd0, 1'b1);
    check("R7 small", int'(sample), round_model(15));
    apply(16'h0100, 8'd7, 16'd0, 1'b1);
    check("R7 mid", int'(sample), round_model(1792));
    apply(16'h0124, 8'd7, 16'd0, 1'b1);
    check("R7 top", int'(sample), round_model(2044));
    apply(16'h7F00, 8'd4, 16'd0, 1'b1);
    check("R7 fold", int'(sample), round_model(1020));
    apply(16'h8100, 8'd7, 16'd0, 1'b1);
    check("R7 neg", int'(sample), round_model(-1792));
    apply(16'hC000, 8'd255, 16'd0, 1'b1);
    check("R7 sat", int'(sample), -2047);

    // R1 asynchronous reset mid-run
    apply(16'h0100, 8'd7, 16'd100, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async sample", int'(sample), 0);
    check("R1 async err", int'(cfg_err), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule